// File: doc/BRIEF.md
# Three/Four-Wire Serial Configuration Register Slave

This block lets an external host read and write the chip's configuration registers over a simple serial link. The host pulls an active-low enable, clocks in a 16-bit instruction and then moves a 16-bit data word. The instruction is a direction flag followed by a 15-bit register address. Writes arrive on the shared data pin. Read data goes back either on a dedicated serial output (4-wire mode) or on the shared data pin, which turns around halfway through the frame (3-wire mode).

Inside the chip the block acts as master of a parallel register bus with an address, write data, a one-cycle write strobe, a one-cycle read request and returned read data. It also splits the address into a 5-bit module code and a 6-bit register field, and raises one select line per addressed module. A module code can be shared by two half-size modules that are told apart by the top register bit. The serial inputs are oversampled by the block's own clock through synchronizers. The pad ring builds the actual tri-state buffers from the output and output-enable pairs.

Top module: `cfg_spi_slave`

## Requirements
- R1: Serial bits are taken on rising SCLK edges. Bit 1 of a frame is the direction flag (1 = write, 0 = read). Bits 2 to 16 are the address, most significant bit first. `rb_addr` holds that address while `rb_we` or `rb_re` is high.
- R2: A write frame produces exactly one single-cycle `rb_we` pulse after the 32nd rising edge. At that point `rb_wdata` holds bits 17 to 32, most significant bit first.
- R3: A read frame produces exactly one single-cycle `rb_re` pulse after the 16th rising edge, before the first data bit is driven. A write frame produces no `rb_re`, and `rb_we` and `rb_re` are never high together.
- R4: With `three_wire`=0, read data D15 down to D0 appears on `sdo_o`, one bit per falling SCLK edge, starting at the fall after the 16th rise. `sdo_oe` is high for those 16 bits and `sdio_oe` stays low.
- R5: With `three_wire`=1, read data appears the same way on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low. The two enables are never high at once.
- R6: The returned read word is the value of `rb_rdata` in the clock cycle in which `rb_re` is high.
- R7: Raising `cs_n` before the 32nd rising edge discards the frame. A write then produces no `rb_we`, a read stopped before 16 bits produces no `rb_re`, and the next frame decodes normally.
- R8: `mod_sel` is one-hot or zero. If address bits 14:11 are not all zero, it is zero. Otherwise the module code c = address bits 10:6 and the half bit h = address bit 5 select bit 2c+h when bit c of SPLIT_MASK is set, and bit 2c when it is not. The default SPLIT_MASK is 32'h0001_0101.
- R9: Both output enables are low during the instruction bits, after the data bits and while `cs_n` is high.
- R10: Rising SCLK edges after the 32nd in one frame are ignored. A write with extra clocks still gives one strobe with the data of bits 17 to 32.
- R11: After reset both output enables are low and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1: read data on shared pin, 0: on dedicated output |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame enable |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output value |
| sdio_oe | output | 1 | Shared data pin, drive enable |
| sdo_o | output | 1 | Dedicated read data output value |
| sdo_oe | output | 1 | Dedicated read data drive enable |
| rb_addr | output | 15 | Register bus address |
| rb_wdata | output | 16 | Register bus write data |
| rb_we | output | 1 | Register bus write strobe, one cycle |
| rb_re | output | 1 | Register bus read request, one cycle |
| rb_rdata | input | 16 | Register bus read data, sampled while rb_re is high |
| mod_sel | output | 64 | One select per module code and half |

## Verification
If the bit counter is off by one, the address at the first strobe is shifted by one position and the strobe lands one SCLK period early or late. A mix-up in the direction flag shows as a missing or wrong strobe in that same frame. A wrong output-enable or shift state shows within one SCLK period of the 16th rise as a wrong pin enable or a wrong read bit. The sweeps cover every module code and half bit, 4-wire and 3-wire reads, frames cut short, and frames with extra clocks, so each such fault reaches a port within the frame that triggers it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int ADDR_W     = 15;
    localparam int DATA_W     = 16;
    localparam int MOD_W      = 5;
    localparam int REG_W      = 6;
    localparam int SYNC_DEPTH = 2;
    localparam int HDR_LEN    = 1 + ADDR_W;
    localparam int FRAME_LEN  = HDR_LEN + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);
    localparam int SEL_W      = 2 ** (MOD_W + 1);
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                st_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                st_q[s] <= st_d[s];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_mod_decode.sv
module spi_mod_decode #(
    parameter int          ADDR_W     = spi_cfg_pkg::ADDR_W,
    parameter int          MOD_W      = spi_cfg_pkg::MOD_W,
    parameter int          REG_W      = spi_cfg_pkg::REG_W,
    parameter logic [31:0] SPLIT_MASK = 32'h0001_0101,
    parameter int          SEL_W      = 2 ** (MOD_W + 1)
) (
    // address bits from the top down to the register half bit
    input  logic [ADDR_W-REG_W:0] addr_hi,
    output logic [SEL_W-1:0]      sel
);
    localparam int UP_W   = ADDR_W - MOD_W - REG_W;
    localparam int N_CODE = 2 ** MOD_W;

    logic             upper_ok;
    logic [MOD_W-1:0] code;
    logic             half;

    assign upper_ok = (addr_hi[ADDR_W-REG_W -: UP_W] == '0);
    assign code     = addr_hi[MOD_W:1];
    assign half     = addr_hi[0];

    for (genvar g = 0; g < N_CODE; g++) begin : g_code
        for (genvar h = 0; h < 2; h++) begin : g_half
            if (SPLIT_MASK[g]) begin : g_split
                assign sel[2*g+h] = upper_ok && (code == MOD_W'(g)) && (half == 1'(h));
            end else if (h == 0) begin : g_full
                assign sel[2*g+h] = upper_ok && (code == MOD_W'(g));
            end else begin : g_unused
                assign sel[2*g+h] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
    parameter int ADDR_W = spi_cfg_pkg::ADDR_W,
    parameter int DATA_W = spi_cfg_pkg::DATA_W,
    parameter int CNT_W  = $clog2(1 + ADDR_W + DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    output logic              rb_we,
    output logic              rb_re,
    output logic              drv,
    output logic              dout
);
    localparam int              HDR   = 1 + ADDR_W;
    localparam int              FRAME = HDR + DATA_W;
    localparam logic [CNT_W-1:0] ADDR_LAST_C = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] HDR_C       = CNT_W'(HDR);
    localparam logic [CNT_W-1:0] FRAME_C     = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] LAST_C      = CNT_W'(FRAME - 1);

    typedef struct packed {
        logic              sck;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sh;
        logic              we;
        logic              re;
        logic              drv;
        logic              dout;
    } frame_st_t;

    frame_st_t st_q, st_d;
    logic      rise, fall;

    assign rise = sclk_s & ~st_q.sck;
    assign fall = ~sclk_s & st_q.sck;

    always_comb begin
        st_d     = st_q;
        st_d.sck = sclk_s;
        st_d.we  = 1'b0;
        st_d.re  = 1'b0;
        // the register bus answers in the cycle of the request
        if (st_q.re) begin
            st_d.sh = rb_rdata;
        end
        if (cs_n_s) begin
            st_d.cnt = '0;
            st_d.wr  = 1'b0;
            st_d.drv = 1'b0;
        end else if (rise && st_q.cnt != FRAME_C) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == '0) begin
                st_d.wr = din_s;
            end else if (st_q.cnt <= ADDR_LAST_C) begin
                st_d.addr = {st_q.addr[ADDR_W-2:0], din_s};
            end else if (st_q.wr) begin
                st_d.sh = {st_q.sh[DATA_W-2:0], din_s};
            end
            if (st_q.cnt == ADDR_LAST_C && !st_q.wr) begin
                st_d.re = 1'b1;
            end
            if (st_q.cnt == LAST_C && st_q.wr) begin
                st_d.we = 1'b1;
            end
        end else if (fall) begin
            if (!st_q.wr && st_q.cnt >= HDR_C && st_q.cnt < FRAME_C) begin
                st_d.drv  = 1'b1;
                st_d.dout = st_q.sh[DATA_W-1];
                st_d.sh   = {st_q.sh[DATA_W-2:0], 1'b0};
            end else begin
                st_d.drv  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rb_addr  = st_q.addr;
    assign rb_wdata = st_q.sh;
    assign rb_we    = st_q.we;
    assign rb_re    = st_q.re;
    assign drv      = st_q.drv;
    assign dout     = st_q.dout;

    AST_RE_AT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.re |-> (st_q.cnt == HDR_C) && !st_q.wr); // R3
    AST_WE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> (st_q.cnt == FRAME_C) && st_q.wr); // R2
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !st_q.drv); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FRAME_C); // R10
    AST_DRV_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drv |-> !st_q.wr); // R4
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
    parameter int          ADDR_W     = spi_cfg_pkg::ADDR_W,
    parameter int          DATA_W     = spi_cfg_pkg::DATA_W,
    parameter int          MOD_W      = spi_cfg_pkg::MOD_W,
    parameter int          REG_W      = spi_cfg_pkg::REG_W,
    parameter int          SYNC_DEPTH = spi_cfg_pkg::SYNC_DEPTH,
    parameter logic [31:0] SPLIT_MASK = 32'h0001_0101,
    parameter int          SEL_W      = 2 ** (MOD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    output logic              rb_we,
    output logic              rb_re,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic [SEL_W-1:0]  mod_sel
);
    logic [2:0] pins_s;
    logic       drv, dout;

    spi_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, sdio_i}),
        .q     (pins_s)
    );

    spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[2]),
        .cs_n_s   (pins_s[1]),
        .din_s    (pins_s[0]),
        .rb_rdata (rb_rdata),
        .rb_addr  (rb_addr),
        .rb_wdata (rb_wdata),
        .rb_we    (rb_we),
        .rb_re    (rb_re),
        .drv      (drv),
        .dout     (dout)
    );

    spi_mod_decode #(
        .ADDR_W(ADDR_W), .MOD_W(MOD_W), .REG_W(REG_W),
        .SPLIT_MASK(SPLIT_MASK), .SEL_W(SEL_W)
    ) i_dec (
        .addr_hi (rb_addr[ADDR_W-1:REG_W-1]),
        .sel     (mod_sel)
    );

    assign sdo_o   = dout;
    assign sdio_o  = dout;
    assign sdo_oe  = drv & ~three_wire;
    assign sdio_oe = drv & three_wire;

    AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe)); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_sel)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_we && rb_re)); // R3
endmodule

// File: tb/test_cfg_spi_slave.sv
module test_cfg_spi_slave;
    localparam int          HALF  = 5;
    localparam logic [31:0] SPLIT = 32'h0001_0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        three_wire = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdio_i = 1'b0;
    logic        sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [14:0] rb_addr;
    logic [15:0] rb_wdata, rb_rdata;
    logic        rb_we, rb_re;
    logic [63:0] mod_sel;

    int n_cmp = 0;
    int n_bad = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [14:0] last_waddr, last_raddr;
    logic [15:0] last_wdata;
    logic [63:0] last_sel;

    always #10 clk = ~clk;

    cfg_spi_slave i_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .sclk(sclk),
        .cs_n(cs_n), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
        .rb_we(rb_we), .rb_re(rb_re), .rb_rdata(rb_rdata), .mod_sel(mod_sel)
    );

    function automatic logic [15:0] mdl(input logic [14:0] a);
        return 16'({1'b0, a} * 16'd37) ^ 16'h5A3C;
    endfunction

    function automatic logic [63:0] exp_sel(input logic [14:0] a);
        int code, h;
        if ((a >> 11) != 0) return 64'd0;
        code = int'((a >> 6) & 15'd31);
        h    = SPLIT[code] ? int'((a >> 5) & 15'd1) : 0;
        return 64'd1 << (code * 2 + h);
    endfunction

    assign rb_rdata = mdl(rb_addr);

    always @(negedge clk) begin
        if (rb_we) begin
            we_cnt++;
            last_waddr = rb_addr;
            last_wdata = rb_wdata;
            last_sel   = mod_sel;
        end
        if (rb_re) begin
            re_cnt++;
            last_raddr = rb_addr;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [47:0] fr, input int nbits, input logic three,
                        output logic [15:0] rd, output int oe_bad, output int re_at16);
        int base_re;
        three_wire = three;
        @(negedge clk);
        cs_n = 1'b0;
        oe_bad = 0;
        rd = '0;
        re_at16 = -1;
        base_re = re_cnt;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdio_i = fr[47-i];
            repeat (HALF) @(negedge clk);
            if (i >= 16 && i < 32 && fr[47] == 1'b0) begin
                rd[31-i] = three ? sdio_o : sdo_o;
                if (three ? !(sdio_oe && !sdo_oe) : !(sdo_oe && !sdio_oe)) oe_bad++;
                if (i == 16) re_at16 = re_cnt - base_re;
            end else if (sdo_oe || sdio_oe) begin
                oe_bad++;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (nbits >= 32 && (sdo_oe || sdio_oe)) oe_bad++;
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        if (sdo_oe || sdio_oe) oe_bad++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int oe_bad, re16, w0, r0;
        logic [14:0] a;
        logic [15:0] d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 sdo_oe", 64'(sdo_oe), 64'd0);
        check("R11 sdio_oe", 64'(sdio_oe), 64'd0);
        check("R11 strobes", 64'(we_cnt + re_cnt), 64'd0);

        // write sweep over every module code and half bit
        for (int k = 0; k < 64; k++) begin
            a = 15'(((k >> 1) << 6) | ((k & 1) << 5) | ((k * 7) & 31));
            d = 16'(k * 1021) ^ 16'h3C5A;
            w0 = we_cnt; r0 = re_cnt;
            xfer({1'b1, a, d, 16'hA5F0}, 32, k[0], rd, oe_bad, re16);
            check("R2 one write strobe", 64'(we_cnt - w0), 64'd1);
            check("R1 write address", 64'(last_waddr), 64'(a));
            check("R2 write data", 64'(last_wdata), 64'(d));
            check("R8 module select", last_sel, exp_sel(a));
            check("R3 no read request on write", 64'(re_cnt - r0), 64'd0);
            check("R9 enables low on write", 64'(oe_bad), 64'd0);
        end

        // R8: nonzero upper address bits select nothing
        for (int k = 1; k < 16; k++) begin
            a = 15'((k << 11) | (k * 97));
            xfer({1'b1, a, 16'h1234, 16'h0}, 32, 1'b0, rd, oe_bad, re16);
            check("R8 upper bits give no select", last_sel, 64'd0);
        end

        // reads in both modes
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 20; k++) begin
                a = 15'(k * 1237 + 11 + m * 5);
                w0 = we_cnt; r0 = re_cnt;
                xfer({1'b0, a, 16'hFFFF, 16'h0}, 32, m[0], rd, oe_bad, re16);
                if (m == 0) check("R4 four-wire read data", 64'(rd), 64'(mdl(a)));
                else        check("R5 three-wire read data", 64'(rd), 64'(mdl(a)));
                check("R6 read word from request cycle", 64'(rd), 64'(mdl(last_raddr)));
                check("R1 read address", 64'(last_raddr), 64'(a));
                check("R3 one read request", 64'(re_cnt - r0), 64'd1);
                check("R3 request before data", 64'(re16), 64'd1);
                check("R3 no write strobe on read", 64'(we_cnt - w0), 64'd0);
                if (m == 0) check("R4 pin enables", 64'(oe_bad), 64'd0);
                else        check("R5 pin enables", 64'(oe_bad), 64'd0);
            end
        end

        // R7: aborted frames
        w0 = we_cnt;
        xfer({1'b1, 15'h0155, 16'hBEEF, 16'h0}, 20, 1'b0, rd, oe_bad, re16);
        check("R7 aborted write no strobe", 64'(we_cnt - w0), 64'd0);
        w0 = we_cnt;
        xfer({1'b1, 15'h0155, 16'hBEEF, 16'h0}, 31, 1'b0, rd, oe_bad, re16);
        check("R7 write one bit short no strobe", 64'(we_cnt - w0), 64'd0);
        r0 = re_cnt;
        xfer({1'b0, 15'h02AA, 16'h0, 16'h0}, 10, 1'b1, rd, oe_bad, re16);
        check("R7 aborted read no request", 64'(re_cnt - r0), 64'd0);
        r0 = re_cnt;
        xfer({1'b0, 15'h0321, 16'h0, 16'h0}, 22, 1'b0, rd, oe_bad, re16);
        check("R7 read cut in data phase released", 64'(sdo_oe | sdio_oe), 64'd0);
        w0 = we_cnt;
        xfer({1'b1, 15'h0042, 16'h6B1D, 16'h0}, 32, 1'b0, rd, oe_bad, re16);
        check("R7 next frame strobe", 64'(we_cnt - w0), 64'd1);
        check("R7 next frame address", 64'(last_waddr), 64'h0042);
        check("R7 next frame data", 64'(last_wdata), 64'h6B1D);

        // R10: extra clocks after 32 bits
        w0 = we_cnt;
        xfer({1'b1, 15'h0777, 16'hC0DE, 16'h5A5A}, 40, 1'b0, rd, oe_bad, re16);
        check("R10 one strobe with extra clocks", 64'(we_cnt - w0), 64'd1);
        check("R10 data unaffected", 64'(last_wdata), 64'hC0DE);
        r0 = re_cnt;
        xfer({1'b0, 15'h0123, 16'h0, 16'hFFFF}, 40, 1'b0, rd, oe_bad, re16);
        check("R10 read data with extra clocks", 64'(rd), 64'(mdl(15'h0123)));
        check("R9 released after data bits", 64'(oe_bad), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule